// File: doc/BRIEF.md
# Hint-Aware LRU Set-Associative Cache Controller

This block holds the tag, valid and replacement state of a set-associative cache and answers one lookup at a time. Each request carries a byte address and a one-bit non-temporal hint. On a hit the block reports the way that holds the line. On a miss it picks a way to replace, waits for a built-in memory stub to signal that the fill is complete, installs the new tag and then reports the miss. The data array, write-back and coherence are handled elsewhere.

Each set keeps a full least-recently-used ordering, stored as a permutation of way numbers from least to most recently used. A normal access moves the line it touches to the most-recently-used end. A hinted access, whether it hits or fills, leaves the ordering unchanged. A line brought in by a hinted miss therefore inherits the lowest rank of the line it replaced and is the first candidate the next time that set misses. Invalid ways are always filled before a valid way is evicted. A package helper recovers the hint from the 16-bit annotation field at the top of a 64-bit instruction word.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the requester must hold the address and hint stable until then. `req_ready` stays high while the controller is idle, so hits can be issued back to back. It drops for the whole of a fill, and a request offered during that time is neither taken nor answered. The response is a one-cycle `rsp_valid` pulse with no back-pressure.

Top module: `hint_lru_cache`

## Requirements
- R1: After reset every way of every set is invalid, `req_ready` is 1 and `rsp_valid` is 0. The first access to any set after reset misses, even if the same address was resident before the reset.
- R2: A request that hits is answered in the cycle right after the edge that takes it. The answer is a one-cycle pulse with `rsp_hit`=1 and `rsp_way` equal to the way that holds the line.
- R3: A request that misses is answered with `rsp_hit`=0 exactly FILL_LAT (default 40) cycles later than a hit would be, and `rsp_way` equals `rsp_victim`. The new tag is installed, so repeating the same address then hits in that way.
- R4: While a set has at least one invalid way, a miss fills the lowest-numbered invalid way.
- R5: A normal access (`req_hint`=0), whether a hit or a fill, makes the touched way the most recently used way of its set.
- R6: A hinted access (`req_hint`=1) leaves the set's rank order unchanged on a hit and on a fill. A hinted miss is still allocated and installed. A line filled by a hinted miss keeps the lowest rank and is evicted by the next miss to that set.
- R7: When every way of the set is valid, a miss evicts the least recently used way. On every response, `rsp_victim` is the way the set would replace, taken before the access updates the set.
- R8: After every update the rank state of each set is a permutation of the way numbers.
- R9: `hint_from_insn` returns bit 48 of a 64-bit instruction word. Bit 48 is the lowest bit of the annotation field in bits 63:48, and no other bit affects the result.
- R10: With NUM_WAYS=1 the block behaves as a direct-mapped cache. Every miss uses way 0, and the hint has no effect on hits or misses.
- R11: `req_ready` is 0 from the edge that takes a miss until its response. A request held valid during that time is neither taken nor answered, and its tag is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address: offset, then set index, then tag, from the low bits up |
| req_hint | input | 1 | Non-temporal hint: 1 leaves the rank order unchanged |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | 1 on a hit, 0 on a completed miss |
| rsp_way | output | WAY_W | Way that was hit or filled |
| rsp_victim | output | WAY_W | Replacement candidate of the set before this access |

## Verification
A corrupted rank order shows at the ports on the next miss to the affected set, as a wrong `rsp_victim` and `rsp_way`. A rank order that is wrong only because a hinted access promoted its line shows when a later miss evicts a line that should have stayed and the following access to that line misses. A tag or valid fault shows on the very next access to that set, as a hit/miss flip together with a response 40 cycles early or late. The request table drives one set through hinted and normal hits and fills until every line has been evicted at least once, so each ordering mistake reaches the victim output within a few requests.

// File: rtl/hlc_pkg.sv
package hlc_pkg;

  // Position of the hint flag: the lowest bit of the 16-bit annotation
  // field that occupies bits 63:48 of a 64-bit instruction word.
  localparam int HINT_BIT = 48;

  typedef enum logic {
    ST_IDLE,
    ST_FILL
  } ctl_state_e;

  function automatic logic hint_from_insn(input logic [63:0] insn);
    return insn[HINT_BIT];
  endfunction

endpackage

// File: rtl/hlc_tag_store.sv
module hlc_tag_store #(
  parameter int NUM_SETS = 256,
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 21,
  parameter int IDX_W    = $clog2(NUM_SETS),
  parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic [TAG_W-1:0]    rd_tag,
  output logic [NUM_WAYS-1:0] hit_vec,
  output logic [WAY_W-1:0]    hit_way,
  output logic [NUM_WAYS-1:0] valid_vec,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [WAY_W-1:0]    wr_way,
  input  logic [TAG_W-1:0]    wr_tag
);

  logic [TAG_W-1:0]    tag_mem [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] vld_q   [NUM_SETS];

  // Valid bits are reset; the tags are only written by a fill.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx][wr_way] <= wr_tag;
  end

  assign valid_vec = vld_q[rd_idx];

  // Compare every way of the selected set in parallel.
  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign hit_vec[w] = vld_q[rd_idx][w] && (tag_mem[rd_idx][w] == rd_tag);
    end
  endgenerate

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/hlc_rank_store.sv
module hlc_rank_store #(
  parameter int NUM_SETS = 256,
  parameter int NUM_WAYS = 4,
  parameter int IDX_W    = $clog2(NUM_SETS),
  parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [NUM_WAYS-1:0][WAY_W-1:0] rd_order,
  input  logic                           upd_en,
  input  logic [IDX_W-1:0]               upd_idx,
  input  logic [WAY_W-1:0]               upd_way
);

  // Entry 0 of each set is the least recently used way and the last
  // entry is the most recently used way.
  logic [NUM_WAYS-1:0][WAY_W-1:0] order_q [NUM_SETS];
  logic [NUM_WAYS-1:0][WAY_W-1:0] cur_order;
  logic [NUM_WAYS-1:0][WAY_W-1:0] nxt_order;

  assign cur_order = order_q[upd_idx];

  // Promote upd_way: the entries above its slot move down one place and
  // upd_way goes to the top.
  always_comb begin
    int pos;
    pos = 0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (cur_order[i] == upd_way) pos = i;
    end
    nxt_order = cur_order;
    for (int i = 0; i < NUM_WAYS - 1; i++) begin
      if (i >= pos) nxt_order[i] = cur_order[i+1];
    end
    nxt_order[NUM_WAYS-1] = upd_way;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) order_q[s][w] <= WAY_W'(w);
      end
    end else if (upd_en) begin
      order_q[upd_idx] <= nxt_order;
    end
  end

  assign rd_order = order_q[rd_idx];

endmodule

// File: rtl/hlc_victim.sv
module hlc_victim #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0]            valid_vec,
  input  logic [NUM_WAYS-1:0][WAY_W-1:0] order,
  output logic [WAY_W-1:0]               victim
);

  // The lowest-numbered invalid way wins; if every way is valid, the
  // least recently used way is replaced.
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = order[0];
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!valid_vec[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hlc_fill_stub.sv
module hlc_fill_stub #(
  parameter int FILL_LAT = 40,
  parameter int CNT_W    = $clog2(FILL_LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  // done rises FILL_LAT edges after the edge that sees start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(FILL_LAT - 1);
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/hint_lru_cache.sv
module hint_lru_cache #(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 256,
  parameter int NUM_WAYS   = 4,
  parameter int LINE_BYTES = 8,
  parameter int FILL_LAT   = 40,
  parameter int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_hint,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [WAY_W-1:0]  rsp_victim
);

  import hlc_pkg::*;

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  ctl_state_e state_q;

  logic [IDX_W-1:0] cap_idx;
  logic [TAG_W-1:0] cap_tag;
  logic             cap_hint;
  logic [WAY_W-1:0] cap_victim;

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag;

  logic [NUM_WAYS-1:0]            hit_vec;
  logic [NUM_WAYS-1:0]            valid_vec;
  logic [WAY_W-1:0]               hit_way;
  logic [NUM_WAYS-1:0][WAY_W-1:0] rd_order;
  logic [WAY_W-1:0]               victim;

  logic accept;
  logic lookup_hit;
  logic miss_start;
  logic fill_done;
  logic upd_en;
  logic [IDX_W-1:0] upd_idx;
  logic [WAY_W-1:0] upd_way;

  logic             rsp_valid_q;
  logic             rsp_hit_q;
  logic [WAY_W-1:0] rsp_way_q;
  logic [WAY_W-1:0] rsp_victim_q;

  logic unused_offset;
  assign unused_offset = ^req_addr[OFF_W-1:0];

  assign req_idx = req_addr[OFF_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;

  // The tag and rank stores read the incoming request while idle and the
  // captured set while a fill is pending.
  assign rd_idx     = req_ready ? req_idx : cap_idx;
  assign rd_tag     = req_ready ? req_tag : cap_tag;
  assign lookup_hit = |hit_vec;
  assign miss_start = accept && !lookup_hit;

  // One rank update per cycle: from a normal hit while idle, or from a
  // normal fill when it completes. Hinted accesses never update.
  assign upd_en  = (accept && lookup_hit && !req_hint) || (fill_done && !cap_hint);
  assign upd_idx = fill_done ? cap_idx : req_idx;
  assign upd_way = fill_done ? cap_victim : hit_way;

  hlc_tag_store #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .TAG_W    (TAG_W),
    .IDX_W    (IDX_W),
    .WAY_W    (WAY_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (rd_idx),
    .rd_tag    (rd_tag),
    .hit_vec   (hit_vec),
    .hit_way   (hit_way),
    .valid_vec (valid_vec),
    .wr_en     (fill_done),
    .wr_idx    (cap_idx),
    .wr_way    (cap_victim),
    .wr_tag    (cap_tag)
  );

  hlc_rank_store #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .IDX_W    (IDX_W),
    .WAY_W    (WAY_W)
  ) u_rank (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_order (rd_order),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .upd_way  (upd_way)
  );

  hlc_victim #(
    .NUM_WAYS (NUM_WAYS),
    .WAY_W    (WAY_W)
  ) u_victim (
    .valid_vec (valid_vec),
    .order     (rd_order),
    .victim    (victim)
  );

  hlc_fill_stub #(
    .FILL_LAT (FILL_LAT)
  ) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .start (miss_start),
    .done  (fill_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cap_idx    <= '0;
      cap_tag    <= '0;
      cap_hint   <= 1'b0;
      cap_victim <= '0;
    end else if (miss_start) begin
      state_q    <= ST_FILL;
      cap_idx    <= req_idx;
      cap_tag    <= req_tag;
      cap_hint   <= req_hint;
      cap_victim <= victim;
    end else if (fill_done) begin
      state_q    <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_hit_q    <= 1'b0;
      rsp_way_q    <= '0;
      rsp_victim_q <= '0;
    end else begin
      rsp_valid_q <= (accept && lookup_hit) || fill_done;
      rsp_hit_q   <= accept && lookup_hit;
      if (fill_done) begin
        rsp_way_q    <= cap_victim;
        rsp_victim_q <= cap_victim;
      end else if (accept && lookup_hit) begin
        rsp_way_q    <= hit_way;
        rsp_victim_q <= victim;
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_way    = rsp_way_q;
  assign rsp_victim = rsp_victim_q;

endmodule

// File: rtl/hlc_checker.sv
module hlc_checker #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           accept,
  input logic                           lookup_hit,
  input logic [NUM_WAYS-1:0]            hit_vec,
  input logic [NUM_WAYS-1:0]            valid_vec,
  input logic [WAY_W-1:0]               victim,
  input logic [NUM_WAYS-1:0][WAY_W-1:0] rd_order,
  input logic                           fill_done,
  input logic                           rsp_valid,
  input logic                           rsp_hit,
  input logic                           req_ready
);

  logic [NUM_WAYS-1:0] seen;

  always_comb begin
    seen = '0;
    for (int i = 0; i < NUM_WAYS; i++) seen[rd_order[i]] = 1'b1;
  end

  // R8: the rank entries of the selected set cover every way exactly once.
  p_rank_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    &seen);

  // R2: a tag is held by at most one way of a set.
  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2: a request that hits is answered in the next cycle.
  p_hit_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && lookup_hit |=> rsp_valid && rsp_hit);

  // R11: a miss stalls the request port and gives no early answer.
  p_miss_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lookup_hit |=> !req_ready && !rsp_valid);

  // R3: a completed fill produces a miss response.
  p_fill_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> rsp_valid && !rsp_hit);

  // R4: while an invalid way exists, the candidate is an invalid way.
  p_invalid_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_vec) |-> !valid_vec[victim]);

endmodule

bind hint_lru_cache hlc_checker #(
  .NUM_WAYS (NUM_WAYS),
  .WAY_W    (WAY_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .lookup_hit (lookup_hit),
  .hit_vec    (hit_vec),
  .valid_vec  (valid_vec),
  .victim     (victim),
  .rd_order   (rd_order),
  .fill_done  (fill_done),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .req_ready  (req_ready)
);

// File: tb/hint_lru_cache_tb.sv
`timescale 1ns/1ps
module hint_lru_cache_tb;

  localparam int LAT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // 4-way, 256-set unit
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_hint = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_way, rsp_victim;

  // 1-way, 4-set unit
  logic        req1_valid = 1'b0;
  logic        req1_ready;
  logic [31:0] req1_addr = '0;
  logic        req1_hint = 1'b0;
  logic        rsp1_valid, rsp1_hit;
  logic [0:0]  rsp1_way, rsp1_victim;

  hint_lru_cache #(.NUM_SETS(256), .NUM_WAYS(4), .FILL_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_hint(req_hint), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_victim(rsp_victim));

  hint_lru_cache #(.NUM_SETS(4), .NUM_WAYS(1), .FILL_LAT(LAT)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req1_valid), .req_ready(req1_ready),
    .req_addr(req1_addr), .req_hint(req1_hint), .rsp_valid(rsp1_valid),
    .rsp_hit(rsp1_hit), .rsp_way(rsp1_way), .rsp_victim(rsp1_victim));

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Address layout, 4-way unit: offset 2:0, set 10:3, tag 31:11.
  function automatic logic [31:0] mk(input int t, input int s);
    return (32'(t) << 11) | (32'(s) << 3);
  endfunction

  // Vector: tag[23:16] set[15:8] hint[7] hit[6] way[5:4] victim[3:2]
  function automatic logic [23:0] ent(input int t, input int s, input int h,
                                      input int hit, input int w, input int v);
    return {8'(t), 8'(s), 1'(h), 1'(hit), 2'(w), 2'(v), 2'b00};
  endfunction

  localparam int NV = 17;
  localparam logic [23:0] VEC [NV] = '{
    ent(1, 5, 0, 0, 0, 0),  // R1 R4 R5: order becomes 1,2,3,0
    ent(2, 5, 0, 0, 1, 1),  // R4: 2,3,0,1
    ent(3, 5, 1, 0, 2, 2),  // R6 hinted fill, order unchanged
    ent(4, 5, 0, 0, 3, 3),  // 2,0,1,3
    ent(1, 5, 0, 1, 0, 2),  // R5 hit: 2,1,3,0
    ent(3, 5, 1, 1, 2, 2),  // R6 hinted hit, unchanged
    ent(5, 5, 0, 0, 2, 2),  // R7 hinted line evicted: 1,3,0,2
    ent(3, 5, 0, 0, 1, 1),  // evicted tag misses: 3,0,2,1
    ent(6, 5, 1, 0, 3, 3),  // R6 hinted fill keeps the lowest rank
    ent(7, 5, 0, 0, 3, 3),  // R6 that line goes first: 0,2,1,3
    ent(6, 5, 1, 0, 0, 0),
    ent(6, 5, 0, 1, 0, 0),  // 2,1,3,0
    ent(5, 5, 0, 1, 2, 2),  // 1,3,0,2
    ent(1, 9, 0, 0, 0, 0),  // independent set
    ent(1, 5, 0, 0, 1, 1),  // 3,0,2,1
    ent(7, 5, 1, 1, 3, 3),  // hinted hit does not promote
    ent(9, 5, 0, 0, 3, 3)   // R7
  };

  task automatic do_req(input int t, input int s, input bit h, input bit ehit,
                        input int eway, input int evic, input string lab,
                        input bit intrude);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(t, s); req_hint = h;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 200) begin
      if (intrude && lat < 6) begin
        req_valid = 1'b1; req_addr = mk(8, s); req_hint = 1'b0;
      end else begin
        req_valid = 1'b0;
      end
      chk(!req_ready, "R11 ready low during fill", req_ready, 0);
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk(lat == (ehit ? 1 : 1 + LAT), ehit ? "R2 hit latency" : "R3 miss latency",
        lat, ehit ? 1 : 1 + LAT);
    chk(rsp_hit == ehit, {lab, " hit"}, rsp_hit, ehit);
    chk(rsp_way == 2'(eway), {lab, " way"}, rsp_way, eway);
    chk(rsp_victim == 2'(evic), {lab, " victim"}, rsp_victim, evic);
    @(negedge clk);
    chk(!rsp_valid, "R2 single response pulse", rsp_valid, 0);
  endtask

  task automatic do_req1(input int t, input bit h, input bit ehit);
    int lat;
    @(negedge clk);
    req1_valid = 1'b1; req1_addr = (32'(t) << 5); req1_hint = h;
    @(posedge clk);
    @(negedge clk);
    req1_valid = 1'b0;
    lat = 1;
    while (!rsp1_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(rsp1_hit == ehit, "R10 direct-mapped hit", rsp1_hit, ehit);
    chk(lat == (ehit ? 1 : 1 + LAT), "R10 latency", lat, ehit ? 1 : 1 + LAT);
    chk(rsp1_way == 1'b0, "R10 way", rsp1_way, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);

    // R9 hint helper
    chk(hlc_pkg::hint_from_insn(64'h0001_0000_0000_0000) == 1'b1, "R9 bit 48", 0, 1);
    chk(hlc_pkg::hint_from_insn(64'hFFFE_FFFF_FFFF_FFFF) == 1'b0, "R9 other bits", 1, 0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      do_req(int'(v[23:16]), int'(v[15:8]), v[7], v[6], int'(v[5:4]), int'(v[3:2]),
             (i < 4) ? "R4 fill" : (v[7] ? "R6 hinted" : "R7 order"), 1'b0);
    end

    // R11: a request held during a fill is ignored and not installed.
    do_req(3, 20, 1'b0, 1'b0, 0, 0, "R11 fill", 1'b1);
    do_req(8, 20, 1'b0, 1'b0, 1, 1, "R11 ignored tag absent", 1'b0);
    do_req(3, 20, 1'b0, 1'b1, 0, 2, "R3 repeat hits", 1'b0);

    // R10: one-way unit behaves direct-mapped, hint or not.
    do_req1(1, 1'b0, 1'b0);
    do_req1(1, 1'b0, 1'b1);
    do_req1(2, 1'b1, 1'b0);
    do_req1(2, 1'b1, 1'b1);
    do_req1(1, 1'b0, 1'b0);

    // R1: reset clears residency.
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_req(6, 5, 1'b0, 1'b0, 0, 0, "R1 miss after reset", 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule